// File: doc/BRIEF.md
# Receive Byte-to-Word Packer

This block sits on the receive side of a DMA write path. It accepts received bytes one at a time and gathers them into 64-bit memory words in little-endian lane order: the earliest byte of a word lands in bits 7:0 and later bytes fill higher lanes. A buffer may start at any byte address. The first word of a buffer therefore may begin part way into the word, and the end-of-buffer marker flushes a partly filled last word. Each emitted word carries a per-lane byte enable, its word-aligned address, and a flag that says whether that address needs a single 32-bit address cycle or a dual 64-bit address cycle.

The start address, the lane-reversal mode and the buffer kind (packet data or descriptor) are sampled with the first byte of each buffer. Lane reversal applies to packet data only. Descriptor words always keep little-endian lane order. The output is a single registered word slot with a valid/ready handshake, and a stalled slot stops the byte input.

Top module: `rx_word_packer`

## Requirements
- R1: While reset is held and right after it, out_valid is 0 and in_ready is 1.
- R2: With lane reversal off, the byte accepted at position k of a word goes to lane k (bits 8k+7:8k), and out_be bit k is set for each lane that holds a byte of the buffer. A word is presented on the cycle after the byte that completes it (lane 7, or in_last=1) is accepted.
- R3: The first byte of a buffer goes to lane in_start_addr[2:0]. In the first word, the byte-enable bits below that lane are 0.
- R4: A byte accepted with in_last=1 flushes the current word even if lanes above it are empty. Those lanes have out_be=0, and that word has out_last=1. Every other word has out_last=0.
- R5: The first word of a buffer carries out_addr = in_start_addr with bits 2:0 cleared. Each later word of the same buffer carries the previous address plus 8.
- R6: out_dual is 0 exactly when bits 63:32 of out_addr are all zero (a 32-bit address cycle), and 1 otherwise (a dual 64-bit address cycle).
- R7: For packet data (in_desc=0) with in_swap=1 on the first byte, the lanes of each word are reversed: lane j of the little-endian word appears in lane 7-j of out_data, and out_be is reversed the same way.
- R8: For descriptor data (in_desc=1), in_swap is ignored and words keep little-endian lane order.
- R9: While out_valid=1 and out_ready=0, in_ready is 0 and out_data, out_be, out_addr and out_valid hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The offered byte is taken at this edge |
| in_data | input | 8 | Received byte |
| in_first | input | 1 | Byte is the first of a buffer; start address and modes are sampled with it |
| in_last | input | 1 | Byte is the last of a buffer |
| in_start_addr | input | 64 | Byte address of the buffer start |
| in_swap | input | 1 | 1 selects lane reversal for packet data |
| in_desc | input | 1 | 1 marks the buffer as descriptor data |
| out_valid | output | 1 | A word is presented |
| out_ready | input | 1 | The consumer takes the word at this edge |
| out_data | output | 64 | Packed word |
| out_be | output | 8 | Byte enable per lane, bit k covering bits 8k+7:8k |
| out_addr | output | 64 | Word-aligned address of the word |
| out_dual | output | 1 | 1 when the address needs a dual 64-bit address cycle |
| out_last | output | 1 | Word holds the final byte of its buffer |

## Verification
The assertions assume a well-formed byte stream. The first accepted byte after reset, and every accepted byte after one marked in_last, carries in_first. While a byte waits with in_ready low, in_data and its flags stay unchanged. The stimulus keeps to both rules because one task drives every buffer from its first byte to its last and holds each byte until it is accepted. The consumer side is free: ready is held high, held low, or toggled in a pseudo-random pattern. The patterns cover aligned, unaligned, single-byte and 4 GiB-crossing buffers.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

    typedef enum logic {
        BUF_PACKET = 1'b0,
        BUF_DESC   = 1'b1
    } buf_kind_e;

    typedef struct packed {
        logic      swap;
        buf_kind_e kind;
    } buf_mode_t;

    // Lane reversal is honoured for packet data only
    function automatic logic reverse_wanted(input buf_mode_t m);
        return m.swap && (m.kind == BUF_PACKET);
    endfunction

    function automatic buf_mode_t make_mode(input logic swap, input logic desc);
        buf_mode_t m;
        m.swap = swap;
        m.kind = desc ? BUF_DESC : BUF_PACKET;
        return m;
    endfunction

endpackage

// File: rtl/rxpk_lane_accum.sv
module rxpk_lane_accum #(
    parameter int WORD_BYTES = 8,
    localparam int LB     = $clog2(WORD_BYTES),
    localparam int DATA_W = WORD_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              first,
    input  logic [LB-1:0]     start_lane,
    input  logic [7:0]        byte_in,
    input  logic              last,
    output logic [DATA_W-1:0] merged_data,
    output logic [WORD_BYTES-1:0] merged_be,
    output logic              complete
);

    logic [LB-1:0]         lane_q;
    logic [DATA_W-1:0]     acc_q;
    logic [WORD_BYTES-1:0] be_q;

    logic [LB-1:0]         cur_lane;
    logic [DATA_W-1:0]     base_data;
    logic [WORD_BYTES-1:0] base_be;

    always_comb begin
        cur_lane  = first ? start_lane : lane_q;
        base_data = first ? '0 : acc_q;
        base_be   = first ? '0 : be_q;
        complete  = (cur_lane == LB'(WORD_BYTES - 1)) || last;
    end

    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
        always_comb begin
            merged_data[l*8 +: 8] = (cur_lane == LB'(l)) ? byte_in : base_data[l*8 +: 8];
            merged_be[l]          = base_be[l] | (cur_lane == LB'(l));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
            acc_q  <= '0;
            be_q   <= '0;
        end else if (take) begin
            if (complete) begin
                lane_q <= '0;
                acc_q  <= '0;
                be_q   <= '0;
            end else begin
                lane_q <= cur_lane + LB'(1);
                acc_q  <= merged_data;
                be_q   <= merged_be;
            end
        end
    end

    // A word under construction never loses lanes already filled
    AST_LANES_KEPT: assert property (@(posedge clk) disable iff (rst)
        take && !complete |=> ((be_q & $past(merged_be)) == $past(merged_be))); // R2

endmodule

// File: rtl/rxpk_addr_track.sv
module rxpk_addr_track #(
    parameter int ADDR_W     = 64,
    parameter int WORD_BYTES = 8,
    parameter int LOW_SPACE  = 32,
    localparam int LB = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              first,
    input  logic              complete,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] word_addr,
    output logic              dual
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] aligned_start;

    always_comb begin
        aligned_start = {start_addr[ADDR_W-1:LB], {LB{1'b0}}};
        word_addr     = first ? aligned_start : addr_q;
        dual          = |word_addr[ADDR_W-1:LOW_SPACE];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (take) begin
            addr_q <= complete ? word_addr + ADDR_W'(WORD_BYTES) : word_addr;
        end
    end

endmodule

// File: rtl/rxpk_out_stage.sv
module rxpk_out_stage #(
    parameter int ADDR_W     = 64,
    parameter int WORD_BYTES = 8,
    parameter int LOW_SPACE  = 32,
    localparam int LB     = $clog2(WORD_BYTES),
    localparam int DATA_W = WORD_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  reverse,
    input  logic [DATA_W-1:0]     ld_data,
    input  logic [WORD_BYTES-1:0] ld_be,
    input  logic [ADDR_W-1:0]     ld_addr,
    input  logic                  ld_dual,
    input  logic                  ld_last,
    input  logic                  out_ready,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_data,
    output logic [WORD_BYTES-1:0] out_be,
    output logic [ADDR_W-1:0]     out_addr,
    output logic                  out_dual,
    output logic                  out_last
);

    logic [DATA_W-1:0]     rev_data;
    logic [WORD_BYTES-1:0] rev_be;

    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_rev
        always_comb begin
            rev_data[l*8 +: 8] = ld_data[(WORD_BYTES-1-l)*8 +: 8];
            rev_be[l]          = ld_be[WORD_BYTES-1-l];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_be    <= '0;
            out_addr  <= '0;
            out_dual  <= 1'b0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= reverse ? rev_data : ld_data;
            out_be    <= reverse ? rev_be : ld_be;
            out_addr  <= ld_addr;
            out_dual  <= ld_dual;
            out_last  <= ld_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_LOAD_FREE: assert property (@(posedge clk) disable iff (rst)
        load |-> (!out_valid || out_ready)); // R9

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be)
            && $stable(out_addr) && $stable(out_last)); // R9

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_addr[LB-1:0] == '0)); // R5

    AST_DUAL_CLASS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_dual == (out_addr[ADDR_W-1:LOW_SPACE] != '0))); // R6

    AST_BE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_be != '0)); // R2

endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer
    import rxpk_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int WORD_BYTES = 8,
    parameter int LOW_SPACE  = 32,
    localparam int LB     = $clog2(WORD_BYTES),
    localparam int DATA_W = WORD_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [7:0]            in_data,
    input  logic                  in_first,
    input  logic                  in_last,
    input  logic [ADDR_W-1:0]     in_start_addr,
    input  logic                  in_swap,
    input  logic                  in_desc,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [DATA_W-1:0]     out_data,
    output logic [WORD_BYTES-1:0] out_be,
    output logic [ADDR_W-1:0]     out_addr,
    output logic                  out_dual,
    output logic                  out_last
);

    logic                  take;
    logic                  complete;
    logic                  load;
    logic [DATA_W-1:0]     merged_data;
    logic [WORD_BYTES-1:0] merged_be;
    logic [ADDR_W-1:0]     word_addr;
    logic                  word_dual;
    buf_mode_t             mode_q;
    buf_mode_t             cur_mode;

    // Slot is free when empty or being drained at this edge
    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;
    assign load     = take && complete;

    always_comb begin
        cur_mode = in_first ? make_mode(in_swap, in_desc) : mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= make_mode(1'b0, 1'b0);
        end else if (take && in_first) begin
            mode_q <= make_mode(in_swap, in_desc);
        end
    end

    rxpk_lane_accum #(
        .WORD_BYTES (WORD_BYTES)
    ) u_accum (
        .clk         (clk),
        .rst         (rst),
        .take        (take),
        .first       (in_first),
        .start_lane  (in_start_addr[LB-1:0]),
        .byte_in     (in_data),
        .last        (in_last),
        .merged_data (merged_data),
        .merged_be   (merged_be),
        .complete    (complete)
    );

    rxpk_addr_track #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES),
        .LOW_SPACE  (LOW_SPACE)
    ) u_addr (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .first      (in_first),
        .complete   (complete),
        .start_addr (in_start_addr),
        .word_addr  (word_addr),
        .dual       (word_dual)
    );

    rxpk_out_stage #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES),
        .LOW_SPACE  (LOW_SPACE)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .reverse   (reverse_wanted(cur_mode)),
        .ld_data   (merged_data),
        .ld_be     (merged_be),
        .ld_addr   (word_addr),
        .ld_dual   (word_dual),
        .ld_last   (in_last),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_be    (out_be),
        .out_addr  (out_addr),
        .out_dual  (out_dual),
        .out_last  (out_last)
    );

    // Stream-rule tracking and address-step history for checks
    logic              need_first;
    logic              hist_valid;
    logic [ADDR_W-1:0] hist_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            need_first <= 1'b1;
            hist_valid <= 1'b0;
            hist_addr  <= '0;
        end else begin
            if (take) begin
                need_first <= in_last;
            end
            if (load) begin
                hist_valid <= !in_last;
                hist_addr  <= word_addr;
            end
        end
    end

    AST_FIRST_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        take && need_first |-> in_first); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        load && hist_valid && !in_first |-> (word_addr == hist_addr + ADDR_W'(WORD_BYTES))); // R5

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> !out_valid); // R1

endmodule

// File: tb/tb_rx_word_packer.sv
module tb_rx_word_packer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic [63:0] in_start_addr = '0;
    logic        in_swap = 1'b0;
    logic        in_desc = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;
    logic [7:0]  out_be;
    logic [63:0] out_addr;
    logic        out_dual;
    logic        out_last;

    always #10 clk = ~clk;

    rx_word_packer dut (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .in_first      (in_first),
        .in_last       (in_last),
        .in_start_addr (in_start_addr),
        .in_swap       (in_swap),
        .in_desc       (in_desc),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_data      (out_data),
        .out_be        (out_be),
        .out_addr      (out_addr),
        .out_dual      (out_dual),
        .out_last      (out_last)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [63:0] qd[$];
    logic [7:0]  qbe[$];
    logic [63:0] qa[$];
    logic        qdual[$];
    logic        qlast[$];
    string       qtag[$];

    int        rdy_mode = 1;   // 0 pseudo-random, 1 always ready, 2 never ready
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // Scoreboard monitor: set ready, then compare any word that transfers at the next edge
    always @(negedge clk) begin
        logic r;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        r = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : lfsr[0];
        out_ready = r;
        if (!rst && out_valid && r) begin
            if (qd.size() == 0) begin
                check(1'b0, "R2 unexpected word", out_data, 64'h0);
            end else begin
                logic [63:0] ed, ea;
                logic [7:0]  eb;
                logic        edl, ell;
                string       t;
                ed = qd.pop_front(); eb = qbe.pop_front(); ea = qa.pop_front();
                edl = qdual.pop_front(); ell = qlast.pop_front(); t = qtag.pop_front();
                check(out_data == ed, {t, " data"}, out_data, ed);
                check(out_be == eb, {t, " be"}, 64'(out_be), 64'(eb));
                check(out_addr == ea, {t, " addr"}, out_addr, ea);
                check(out_dual == edl && out_last == ell, {t, " dual/last"},
                      64'({out_dual, out_last}), 64'({edl, ell}));
            end
        end
    end

    task automatic send_buf(input logic [63:0] sa, input int len, input bit sw, input bit ds,
                            input logic [7:0] seed, input string tag);
        logic [63:0] d, a, rd;
        logic [7:0]  be, rb;
        int lane;
        d = '0; be = '0;
        a = {sa[63:3], 3'b000};
        lane = int'(sa[2:0]);
        for (int i = 0; i < len; i++) begin
            d[lane*8 +: 8] = 8'(seed + 8'(i * 7) + 8'(i >> 3));
            be[lane] = 1'b1;
            if (lane == 7 || i == len - 1) begin
                for (int l = 0; l < 8; l++) begin
                    rd[l*8 +: 8] = d[(7-l)*8 +: 8];
                    rb[l] = be[7-l];
                end
                qd.push_back((sw && !ds) ? rd : d);
                qbe.push_back((sw && !ds) ? rb : be);
                qa.push_back(a);
                qdual.push_back(a[63:32] != 32'h0);
                qlast.push_back(i == len - 1);
                qtag.push_back(tag);
                a = a + 64'd8; lane = 0; d = '0; be = '0;
            end else begin
                lane++;
            end
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data = 8'(seed + 8'(i * 7) + 8'(i >> 3));
            in_first = (i == 0);
            in_last = (i == len - 1);
            in_start_addr = sa;
            in_swap = sw;
            in_desc = ds;
            #2;
            while (!in_ready) begin
                @(negedge clk);
                #2;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (qd.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(qd.size() == 0, "R2 scoreboard drained", 64'(qd.size()), 64'h0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'h0);
        check(in_ready == 1'b1, "R1 in_ready in reset", 64'(in_ready), 64'h1);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'h0);

        send_buf(64'h0000_0000_0000_1000, 16, 1'b0, 1'b0, 8'h01, "R2 R5 aligned");
        send_buf(64'h0000_0000_0000_2003, 13, 1'b0, 1'b0, 8'h40, "R3 R4 unaligned");
        send_buf(64'h0000_0001_0000_0FFD, 20, 1'b0, 1'b0, 8'h80, "R6 R5 high");
        send_buf(64'h0000_0000_FFFF_FFFA, 12, 1'b0, 1'b0, 8'h11, "R6 crossing");
        send_buf(64'h0000_0000_0000_3005, 14, 1'b1, 1'b0, 8'h22, "R7 reversed packet");
        send_buf(64'h0000_0000_0000_4002, 14, 1'b1, 1'b1, 8'h33, "R8 descriptor");
        send_buf(64'h0000_0000_0000_5007, 1, 1'b0, 1'b0, 8'h5A, "R3 R4 single byte");
        send_buf(64'h0000_0000_0000_6000, 3, 1'b0, 1'b0, 8'h66, "R4 short");
        drain();

        rdy_mode = 0;
        send_buf(64'h0000_0000_0000_7006, 40, 1'b0, 1'b0, 8'h70, "R9 R2 random ready");
        send_buf(64'h0000_0002_0000_0001, 23, 1'b1, 1'b0, 8'h90, "R7 R9 random ready");
        drain();

        rdy_mode = 2;
        send_buf(64'h0000_0000_0000_8000, 8, 1'b0, 1'b0, 8'hA0, "R9 stall");
        #2;
        check(out_valid == 1'b1, "R9 word held", 64'(out_valid), 64'h1);
        check(in_ready == 1'b0, "R9 in_ready low while stalled", 64'(in_ready), 64'h0);
        held = out_data;
        repeat (4) @(negedge clk);
        #2;
        check(out_valid == 1'b1 && out_data == held, "R9 data stable", out_data, held);
        rdy_mode = 1;
        drain();

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule